// File: doc/BRIEF.md
# Atomic Sequence Ownership Gate

This block stands in front of one core's memory request port and decides, in the same cycle a request is presented, whether that request may enter. It records which processor currently owns an unfinished read-modify-write sequence and how many atomic reads that owner still has open. While ownership is held, every other processor is held off. A non-atomic request from the owner ends the sequence early. A completion pulse for an atomic write hands one unit of ownership back.

A request carries a type code, a processor ID and a probe flag. With the probe flag set, the gate only answers whether the request would be admitted and changes nothing. When a completion and a request arrive in the same cycle, the completion is applied first, and the request is judged against the owner and count that result. Broken invariants and illegal IDs raise a one-cycle error flag and leave the state as it was. The ready output is combinational from the inputs and the held state. Owner, count and error are registered.

Top module: `rmw_owner_gate`

## Requirements
- R1: After a synchronous active-low reset, the owner output reads 200 (the idle sentinel), the count reads 0, the error flag is low, and a legal request from any processor is ready.
- R2: While an owner is held, a request whose processor ID differs from the owner sees ready low and changes nothing. A request from the owner sees ready high.
- R3: An accepted atomic read (type code 3) takes ownership for the requester with count 1 when the gate is idle. From the current owner it increments the count. Either takes effect on the next clock edge.
- R4: An accepted atomic write request (type code 4) leaves owner and count unchanged.
- R5: An accepted request of any other type (0 load, 1 store, 2 ifetch, 5 to 7 other) from the owner returns the owner to 200 and the count to 0. From a processor while the gate is idle, it changes nothing.
- R6: A completion pulse whose ID equals the owner decrements the count. When the count reaches 0, the owner returns to 200.
- R7: A completion pulse whose ID is not the owner, or that arrives while idle, leaves the state unchanged and raises the error flag.
- R8: With the probe flag set, ready reflects admission as usual, but owner and count do not change.
- R9: A valid request with processor ID 100 or 200 sees ready low, changes nothing and raises the error flag. This holds even when probing.
- R10: An atomic read from the owner while the count is at its maximum (15) sees ready low, leaves the count at 15 and, unless probing, raises the error flag.
- R11: A completion and a request in the same cycle are resolved completion first. The request is judged against the owner and count after the completion.
- R12: The error flag is high only in the cycle after an offending event. Otherwise it is low.
- R13: With neither a valid request nor a completion, owner and count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_kind | input | 3 | Request type code |
| req_pid | input | 8 | Requesting processor ID |
| req_probe | input | 1 | Evaluate readiness only, no state change |
| wdone_valid | input | 1 | An atomic write has completed |
| wdone_pid | input | 8 | Processor ID of the completed atomic write |
| req_ready | output | 1 | The presented request is admitted |
| owner_id | output | 8 | Current owner, 200 when idle |
| pend_cnt | output | 4 | Outstanding atomic reads of the owner |
| err_flag | output | 1 | One-cycle pulse after a violation |

## Verification
The bench aims at the cycle where a completion frees the gate while a different processor asks for it. A design that admits before retiring would stall that processor, or would leave the old owner in place. It walks the count to 15 and asks once more. A counter without a saturation guard would wrap to 0 and silently lose ownership. It also covers probes from the owner and from outsiders, stray completions and the two reserved IDs. A gate that updates state on a probe, accepts a completion from a non-owner or admits the sentinel ID would show a wrong owner or count, or a missing error pulse, in the cycle after.

// File: rtl/rmw_gate_pkg.sv
// Shared request-type codes for the atomic ownership gate.
// Assumes a 3-bit type field; codes not listed are non-atomic.
package rmw_gate_pkg;
    localparam int KIND_W = 3;
    localparam logic [KIND_W-1:0] KIND_LOAD   = 3'd0;
    localparam logic [KIND_W-1:0] KIND_STORE  = 3'd1;
    localparam logic [KIND_W-1:0] KIND_IFETCH = 3'd2;
    localparam logic [KIND_W-1:0] KIND_RMW_RD = 3'd3;
    localparam logic [KIND_W-1:0] KIND_RMW_WR = 3'd4;
endpackage

// File: rtl/rmw_retire_stage.sv
// Applies an atomic-write completion to the held owner and count.
// Assumes the caller feeds registered state; the result feeds admission
// in the same cycle. A completion that does not match a live owner with
// a nonzero count is refused and reported as a fault.
module rmw_retire_stage #(
    parameter int PID_W   = 8,
    parameter int CNT_W   = 4,
    parameter int IDLE_ID = 200
) (
    input  logic [PID_W-1:0] owner_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             done_valid,
    input  logic [PID_W-1:0] done_pid,
    output logic [PID_W-1:0] owner_r,
    output logic [CNT_W-1:0] cnt_r,
    output logic             fault
);
    localparam logic [PID_W-1:0] IDLE_V = PID_W'(IDLE_ID);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic match;

    // Decide whether the completion belongs to the live owner.
    always_comb begin
        match = (owner_q != IDLE_V) && (owner_q == done_pid) && (cnt_q != '0);
        fault = done_valid && !match;
    end

    // Decrement on a matching completion; release at the last one.
    always_comb begin
        owner_r = owner_q;
        cnt_r   = cnt_q;
        if (done_valid && match) begin
            cnt_r = cnt_q - ONE;
            if (cnt_q == ONE) begin
                owner_r = IDLE_V;
            end
        end
    end
endmodule

// File: rtl/rmw_admit_stage.sv
// Judges one request against the post-completion owner and count and
// produces ready plus the next state. Assumes the inputs already reflect
// any completion of this cycle. Probes never change state.
module rmw_admit_stage
    import rmw_gate_pkg::*;
#(
    parameter int PID_W   = 8,
    parameter int CNT_W   = 4,
    parameter int IDLE_ID = 200,
    parameter int BAD_ID  = 100
) (
    input  logic [PID_W-1:0]  owner_r,
    input  logic [CNT_W-1:0]  cnt_r,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [PID_W-1:0]  req_pid,
    input  logic              req_probe,
    output logic              ready,
    output logic [PID_W-1:0]  owner_n,
    output logic [CNT_W-1:0]  cnt_n,
    output logic              fault
);
    localparam logic [PID_W-1:0] IDLE_V  = PID_W'(IDLE_ID);
    localparam logic [PID_W-1:0] BAD_V   = PID_W'(BAD_ID);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic illegal, foreign, is_rd, is_wr, full, idle_bad, take;

    // Classify the request against the current ownership.
    always_comb begin
        illegal  = (req_pid == BAD_V) || (req_pid == IDLE_V);
        foreign  = (owner_r != IDLE_V) && (owner_r != req_pid);
        is_rd    = (req_kind == KIND_RMW_RD);
        is_wr    = (req_kind == KIND_RMW_WR);
        full     = is_rd && (cnt_r == CNT_MAX);
        idle_bad = (owner_r == IDLE_V) && (cnt_r != '0);
        ready    = !illegal && !foreign && !full;
        take     = req_valid && ready && !req_probe;
    end

    // Flag illegal IDs, saturation and a corrupt idle count.
    always_comb begin
        fault = req_valid && (illegal ||
                              (full && !req_probe) ||
                              (take && is_rd && idle_bad));
    end

    // Compute the owner and count after an accepted request.
    always_comb begin
        owner_n = owner_r;
        cnt_n   = cnt_r;
        if (take) begin
            if (is_rd) begin
                if (owner_r == IDLE_V) begin
                    if (!idle_bad) begin
                        owner_n = req_pid;
                        cnt_n   = ONE;
                    end
                end else begin
                    cnt_n = cnt_r + ONE;
                end
            end else if (!is_wr && (owner_r == req_pid)) begin
                owner_n = IDLE_V;
                cnt_n   = '0;
            end
        end
    end
endmodule

// File: rtl/rmw_state_regs.sv
// Holds owner, count and the one-cycle error pulse.
// Assumes a synchronous active-low reset to the idle sentinel.
module rmw_state_regs #(
    parameter int PID_W   = 8,
    parameter int CNT_W   = 4,
    parameter int IDLE_ID = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PID_W-1:0] owner_d,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             err_d,
    output logic [PID_W-1:0] owner_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             err_q
);
    // Register the next state, or the idle state under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= PID_W'(IDLE_ID);
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            owner_q <= owner_d;
            cnt_q   <= cnt_d;
            err_q   <= err_d;
        end
    end
endmodule

// File: rtl/rmw_owner_gate.sv
// Top of the atomic ownership gate: retire a completion, then admit a
// request against the result, then register the new state. Assumes one
// request and at most one completion per cycle.
module rmw_owner_gate
    import rmw_gate_pkg::*;
#(
    parameter int PID_W   = 8,
    parameter int CNT_W   = 4,
    parameter int IDLE_ID = 200,
    parameter int BAD_ID  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [PID_W-1:0]  req_pid,
    input  logic              req_probe,
    input  logic              wdone_valid,
    input  logic [PID_W-1:0]  wdone_pid,
    output logic              req_ready,
    output logic [PID_W-1:0]  owner_id,
    output logic [CNT_W-1:0]  pend_cnt,
    output logic              err_flag
);
    logic [PID_W-1:0] owner_q, owner_r, owner_n;
    logic [CNT_W-1:0] cnt_q, cnt_r, cnt_n;
    logic             ret_fault, adm_fault, err_q;

    rmw_retire_stage #(.PID_W(PID_W), .CNT_W(CNT_W), .IDLE_ID(IDLE_ID)) u_retire (
        .owner_q    (owner_q),
        .cnt_q      (cnt_q),
        .done_valid (wdone_valid),
        .done_pid   (wdone_pid),
        .owner_r    (owner_r),
        .cnt_r      (cnt_r),
        .fault      (ret_fault)
    );

    rmw_admit_stage #(.PID_W(PID_W), .CNT_W(CNT_W), .IDLE_ID(IDLE_ID), .BAD_ID(BAD_ID)) u_admit (
        .owner_r   (owner_r),
        .cnt_r     (cnt_r),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_pid   (req_pid),
        .req_probe (req_probe),
        .ready     (req_ready),
        .owner_n   (owner_n),
        .cnt_n     (cnt_n),
        .fault     (adm_fault)
    );

    rmw_state_regs #(.PID_W(PID_W), .CNT_W(CNT_W), .IDLE_ID(IDLE_ID)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .owner_d (owner_n),
        .cnt_d   (cnt_n),
        .err_d   (ret_fault | adm_fault),
        .owner_q (owner_q),
        .cnt_q   (cnt_q),
        .err_q   (err_q)
    );

    // Drive the registered state onto the outputs.
    always_comb begin
        owner_id = owner_q;
        pend_cnt = cnt_q;
        err_flag = err_q;
    end
endmodule

// File: rtl/rmw_owner_gate_chk.sv
// Port-level properties of the ownership gate, bound onto its top.
module rmw_owner_gate_chk #(
    parameter int PID_W   = 8,
    parameter int CNT_W   = 4,
    parameter int IDLE_ID = 200,
    parameter int BAD_ID  = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_kind,
    input logic [PID_W-1:0] req_pid,
    input logic             req_probe,
    input logic             wdone_valid,
    input logic [PID_W-1:0] wdone_pid,
    input logic             req_ready,
    input logic [PID_W-1:0] owner_id,
    input logic [CNT_W-1:0] pend_cnt,
    input logic             err_flag
);
    localparam logic [PID_W-1:0] IDLE_V  = PID_W'(IDLE_ID);
    localparam logic [PID_W-1:0] BAD_V   = PID_W'(BAD_ID);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_id == IDLE_V) |-> (pend_cnt == '0));

    p_block_other_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdone_valid && owner_id != IDLE_V && req_pid != owner_id) |-> !req_ready);

    p_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdone_valid && req_valid && !req_probe && req_ready &&
         req_kind == 3'd3 && owner_id == IDLE_V)
        |=> (owner_id == $past(req_pid)) && (pend_cnt == CNT_W'(1)));

    p_stray_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdone_valid && wdone_pid != owner_id) |=> err_flag);

    p_probe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_probe && !wdone_valid) |=> ($stable(owner_id) && $stable(pend_cnt)));

    p_bad_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_pid == BAD_V || req_pid == IDLE_V)) |-> !req_ready);

    p_bad_id_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pid == BAD_V) |=> err_flag);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdone_valid && req_kind == 3'd3 && pend_cnt == CNT_MAX) |-> !req_ready);

    p_quiet_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !wdone_valid) |=> ($stable(owner_id) && $stable(pend_cnt)));
endmodule

bind rmw_owner_gate rmw_owner_gate_chk #(
    .PID_W(PID_W), .CNT_W(CNT_W), .IDLE_ID(IDLE_ID), .BAD_ID(BAD_ID)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_pid     (req_pid),
    .req_probe   (req_probe),
    .wdone_valid (wdone_valid),
    .wdone_pid   (wdone_pid),
    .req_ready   (req_ready),
    .owner_id    (owner_id),
    .pend_cnt    (pend_cnt),
    .err_flag    (err_flag)
);

// File: tb/rmw_owner_gate_test.sv
`timescale 1ns/1ps
module rmw_owner_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [7:0] req_pid = 8'd0;
    logic       req_probe = 1'b0;
    logic       wdone_valid = 1'b0;
    logic [7:0] wdone_pid = 8'd0;
    logic       req_ready;
    logic [7:0] owner_id;
    logic [3:0] pend_cnt;
    logic       err_flag;

    int total = 0;
    int bad = 0;

    typedef struct {
        int    owner;
        int    cnt;
        int    err;
        string tag;
    } exp_t;
    exp_t sb[$];

    rmw_owner_gate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_pid(req_pid), .req_probe(req_probe), .wdone_valid(wdone_valid),
        .wdone_pid(wdone_pid), .req_ready(req_ready), .owner_id(owner_id),
        .pend_cnt(pend_cnt), .err_flag(err_flag)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, check ready, queue the expected state.
    task automatic step(input bit v, input int k, input int p, input bit pr,
                        input bit dv, input int dp, input int exp_rdy,
                        input int eo, input int ec, input int ee, input string tag);
        @(negedge clk);
        req_valid   = v;
        req_kind    = 3'(k);
        req_pid     = 8'(p);
        req_probe   = pr;
        wdone_valid = dv;
        wdone_pid   = 8'(dp);
        #0.5;
        if (exp_rdy >= 0)
            check(int'(req_ready) == exp_rdy, {tag, " ready"}, int'(req_ready), exp_rdy);
        sb.push_back('{owner: eo, cnt: ec, err: ee, tag: tag});
    endtask

    // Monitor: after each edge, compare registered outputs with the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(int'(owner_id) == e.owner, {e.tag, " owner"}, int'(owner_id), e.owner);
                check(int'(pend_cnt) == e.cnt, {e.tag, " count"}, int'(pend_cnt), e.cnt);
                check(int'(err_flag) == e.err, {e.tag, " err"}, int'(err_flag), e.err);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 5000);
        bad++;
        total++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        check(owner_id == 8'd200, "R1 reset owner", int'(owner_id), 200);
        check(pend_cnt == 4'd0, "R1 reset count", int'(pend_cnt), 0);
        check(err_flag == 1'b0, "R1 reset err", int'(err_flag), 0);

        step(1, 0, 3, 0, 0, 0, 1, 200, 0, 0, "R1 R5 idle load");
        step(1, 3, 5, 0, 0, 0, 1, 5, 1, 0, "R3 claim");
        step(1, 0, 7, 0, 0, 0, 0, 5, 1, 0, "R2 foreign load");
        step(1, 3, 5, 0, 0, 0, 1, 5, 2, 0, "R3 nest");
        step(1, 3, 5, 1, 0, 0, 1, 5, 2, 0, "R8 owner probe");
        step(1, 0, 7, 1, 0, 0, 0, 5, 2, 0, "R8 foreign probe");
        step(1, 4, 5, 0, 0, 0, 1, 5, 2, 0, "R4 rmw write");
        step(0, 0, 5, 0, 0, 0, -1, 5, 2, 0, "R13 quiet");
        step(0, 0, 0, 0, 1, 7, -1, 5, 2, 1, "R7 stray completion");
        step(0, 0, 0, 0, 0, 0, -1, 5, 2, 0, "R12 err drops");
        step(0, 0, 0, 0, 1, 5, -1, 5, 1, 0, "R6 decrement");
        step(1, 3, 9, 0, 1, 5, 1, 9, 1, 0, "R11 retire then admit");
        step(1, 1, 9, 0, 0, 0, 1, 200, 0, 0, "R5 store releases");
        step(0, 0, 0, 0, 1, 9, -1, 200, 0, 1, "R7 completion while idle");
        step(1, 0, 100, 0, 0, 0, 0, 200, 0, 1, "R9 id 100");
        step(1, 3, 200, 0, 0, 0, 0, 200, 0, 1, "R9 id 200");
        step(0, 0, 0, 0, 0, 0, -1, 200, 0, 0, "R12 quiet after err");
        for (int i = 0; i < 15; i++)
            step(1, 3, 4, 0, 0, 0, 1, 4, i + 1, 0, "R3 fill");
        step(1, 3, 4, 1, 0, 0, 0, 4, 15, 0, "R10 probe at max");
        step(1, 3, 4, 0, 0, 0, 0, 4, 15, 1, "R10 overflow");
        step(0, 0, 0, 0, 1, 4, -1, 4, 14, 0, "R6 decrement from max");
        step(1, 6, 4, 0, 0, 0, 1, 200, 0, 0, "R5 other kind releases");
        step(1, 3, 2, 0, 0, 0, 1, 2, 1, 0, "R3 claim again");
        step(1, 2, 2, 0, 0, 0, 1, 200, 0, 0, "R5 ifetch releases");
        step(1, 3, 6, 0, 0, 0, 1, 6, 1, 0, "R3 claim for last drop");
        step(0, 0, 0, 0, 1, 6, -1, 200, 0, 0, "R6 last completion frees");
        step(0, 0, 0, 0, 0, 0, -1, 200, 0, 0, "R13 idle hold");

        while (sb.size() > 0) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule